// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers the protection and detection events of a power-path switch into a single interrupt request. Four status sources are sampled as levels: supply present, detection target reached, detection blank period, and switch conducting. Three fault sources arrive as one-cycle set pulses: overvoltage, hard short and over-temperature. Status levels are mirrored in a status register. Fault pulses are latched in a flag register that clears when it is read. An 8-bit mask register selects which sources may raise the request.

The request output `irqPullDown` drives the enable of an external open-drain pull-down, so the pin floats whenever the output is 0. The request rises only when an unmasked bit goes from 0 to 1. It falls on any of these: a read of the status or flag register, 1000 ms of assertion counted on a millisecond tick, the start of a detection window, loss of either supply, or a high level on the disable pin. While either supply is absent, and for a short settle period of ticks after both return, no request can be raised. Read data is combinational from the address. A flag read clears the flags at the clock edge that ends the read strobe cycle.

Top module: `irqEventCtl`

## Requirements
- R1: After reset `irqPullDown` is 0, and the status, flag and mask registers all read 0x00.
- R2: A set pulse latches its flag: overvoltage at bit 2, hard short at bit 1, over-temperature at bit 0 of the flag register (address 3). The flag holds until that register is read. The read returns the latched value, and the flags are 0 afterwards.
- R3: The status register (address 2) shows the levels sampled at the previous clock edge: supply present at bit 7, target at bit 6, timeout at bit 5, switch on at bit 4.
- R4: A mask write stores the byte, which reads back at address 4. Mask bit order from 7 down to 0 is supply, target, timeout, switch, reserved, overvoltage, hard short, over-temperature. The reserved bit 3 always reads 0.
- R5: `irqPullDown` rises one cycle after an unmasked status or flag bit goes from 0 to 1. A masked transition does not raise it, and a level that stays high does not raise it again.
- R6: A read of the status register or the flag register drops `irqPullDown` after that clock edge.
- R7: After 1000 millisecond ticks counted while asserted, `irqPullDown` drops. It is still high after 999 ticks.
- R8: A detection-start pulse drops `irqPullDown`.
- R9: While the disable pin is high, `irqPullDown` is 0 and events do not raise it.
- R10: While either power-good input is low, `irqPullDown` is 0 and events do not raise it. Events are also ignored until 2 ticks after both power-good inputs are high.
- R11: A set pulse in the same cycle as a flag-register read leaves that flag latched. It also leaves `irqPullDown` asserted when the flag is unmasked, because a new event wins over a release.
- R12: Reserved bits, and reads of unmapped addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stsLevel | input | 4 | Status levels {supply, target, timeout, switch} |
| flagSet | input | 3 | Fault set pulses {overvoltage, hard short, over-temp} |
| rdStb | input | 1 | Register read strobe |
| rdAddr | input | 4 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| mskWr | input | 1 | Mask register write strobe |
| mskData | input | 8 | Mask write data |
| detStart | input | 1 | Detection window start pulse |
| vinGood | input | 1 | Input supply power-good |
| vddGood | input | 1 | Logic supply power-good |
| disPin | input | 1 | Disable pin, active high |
| msTick | input | 1 | One-cycle millisecond tick |
| irqPullDown | output | 1 | Drive enable of the open-drain interrupt pull-down |

## Verification
Two situations are hard to reach from the ports. The first is a fault pulse that lands in the exact cycle of a flag read. The stimulus holds `flagSet` high during the read strobe cycle, then checks the value returned by that read, the request, and a second read. The second is the 1000 ms timeout. The bench holds `msTick` high every cycle, so the window closes in about a thousand clocks, and it checks both the 999th and the 1000th tick. The power-up settle window is reached by dropping a supply and sending events before and after the required ticks.

// File: rtl/irqCtlPkg.sv
package irqCtlPkg;
  localparam int REG_W = 8;
  localparam int NUM_STS = 4;
  localparam int NUM_FLG = 3;
  localparam int GAP_W = REG_W - NUM_STS - NUM_FLG;

  typedef struct packed {
    logic clrFlags;
    logic wrMask;
    logic selSts;
    logic selFlag;
    logic selMask;
  } busStrobe_t;
endpackage

// File: rtl/irqCtlDatapath.sv
module irqCtlDatapath
  import irqCtlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_STS-1:0] stsLevel,
  input  logic [NUM_FLG-1:0] flagSet,
  input  logic [REG_W-1:0]   mskData,
  input  busStrobe_t         strobe,
  output logic               trig,
  output logic [REG_W-1:0]   rdData
);
  localparam logic [REG_W-1:0] MASK_KEEP = {{NUM_STS{1'b1}}, {GAP_W{1'b0}}, {NUM_FLG{1'b1}}};

  logic [NUM_STS-1:0] stsQ;
  logic [NUM_FLG-1:0] flagQ;
  logic [REG_W-1:0]   maskQ;
  logic [NUM_STS-1:0] stsRise;
  logic [NUM_FLG-1:0] flagRise;
  logic [REG_W-1:0]   evtVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ  <= '0;
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      stsQ  <= stsLevel;
      flagQ <= (strobe.clrFlags ? '0 : flagQ) | flagSet;
      if (strobe.wrMask) maskQ <= mskData & MASK_KEEP;
    end
  end

  // A set coinciding with a clear counts as a fresh 0-to-1 transition.
  assign stsRise  = stsLevel & ~stsQ;
  assign flagRise = flagSet & (~flagQ | {NUM_FLG{strobe.clrFlags}});
  assign evtVec   = {stsRise, {GAP_W{1'b0}}, flagRise};
  assign trig     = |(evtVec & ~maskQ);

  always_comb begin
    rdData = '0;
    if (strobe.selSts)       rdData = {stsQ, {(REG_W-NUM_STS){1'b0}}};
    else if (strobe.selFlag) rdData = {{(REG_W-NUM_FLG){1'b0}}, flagQ};
    else if (strobe.selMask) rdData = maskQ;
  end

  a_r2_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  a_r11_set_survives_clear: assert property (@(posedge clk) disable iff (!rstN)
    (|flagSet) |=> ((flagQ & $past(flagSet)) == $past(flagSet)));

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlags && !(|flagSet)) |=> (flagQ == '0));
endmodule

// File: rtl/irqCtlControl.sv
module irqCtlControl
  import irqCtlPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STS_ADDR   = 2,
  parameter int FLAG_ADDR  = 3,
  parameter int MASK_ADDR  = 4,
  parameter int TIMEOUT_MS = 1000,
  parameter int SETTLE_MS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              mskWr,
  input  logic              detStart,
  input  logic              vinGood,
  input  logic              vddGood,
  input  logic              disPin,
  input  logic              msTick,
  input  logic              trig,
  output busStrobe_t        strobe,
  output logic              irqOut
);
  localparam int TW = $clog2(TIMEOUT_MS + 1);
  localparam int SW = $clog2(SETTLE_MS + 2);

  logic          irqQ;
  logic [TW-1:0] toCnt;
  logic [SW-1:0] settleCnt;
  logic          armed;
  logic          powered;
  logic          block;
  logic          readRel;
  logic          toHit;

  assign strobe.selSts   = (rdAddr == ADDR_W'(STS_ADDR));
  assign strobe.selFlag  = (rdAddr == ADDR_W'(FLAG_ADDR));
  assign strobe.selMask  = (rdAddr == ADDR_W'(MASK_ADDR));
  assign strobe.clrFlags = rdStb && strobe.selFlag;
  assign strobe.wrMask   = mskWr;

  assign powered = vinGood && vddGood;
  assign block   = !powered || !armed || disPin;
  assign readRel = rdStb && (strobe.selSts || strobe.selFlag);
  assign toHit   = irqQ && msTick && (toCnt == TW'(TIMEOUT_MS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      armed     <= 1'b0;
    end else if (!powered) begin
      settleCnt <= '0;
      armed     <= 1'b0;
    end else if (!armed) begin
      if (settleCnt == SW'(SETTLE_MS)) armed <= 1'b1;
      else if (msTick)                 settleCnt <= settleCnt + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ  <= 1'b0;
      toCnt <= '0;
    end else if (block) begin
      irqQ  <= 1'b0;
      toCnt <= '0;
    end else if (trig) begin
      irqQ  <= 1'b1;
      toCnt <= '0;
    end else if (readRel || detStart || toHit) begin
      irqQ  <= 1'b0;
      toCnt <= '0;
    end else if (irqQ && msTick) begin
      toCnt <= toCnt + TW'(1);
    end
  end

  assign irqOut = irqQ;

  a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rstN)
    disPin |=> !irqQ);

  a_r10_unpowered_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(vinGood && vddGood) |=> !irqQ);

  a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(trig));

  a_r7_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (32'(toCnt) < TIMEOUT_MS));

  a_r8_det_release: assert property (@(posedge clk) disable iff (!rstN)
    (detStart && !trig) |=> !irqQ);
endmodule

// File: rtl/irqEventCtl.sv
module irqEventCtl
  import irqCtlPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STS_ADDR   = 2,
  parameter int FLAG_ADDR  = 3,
  parameter int MASK_ADDR  = 4,
  parameter int TIMEOUT_MS = 1000,
  parameter int SETTLE_MS  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_STS-1:0] stsLevel,
  input  logic [NUM_FLG-1:0] flagSet,
  input  logic               rdStb,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  input  logic               mskWr,
  input  logic [REG_W-1:0]   mskData,
  input  logic               detStart,
  input  logic               vinGood,
  input  logic               vddGood,
  input  logic               disPin,
  input  logic               msTick,
  output logic               irqPullDown
);
  busStrobe_t strobe;
  logic       trig;

  irqCtlControl #(
    .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .FLAG_ADDR(FLAG_ADDR),
    .MASK_ADDR(MASK_ADDR), .TIMEOUT_MS(TIMEOUT_MS), .SETTLE_MS(SETTLE_MS)
  ) uControl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdAddr(rdAddr), .mskWr(mskWr),
    .detStart(detStart), .vinGood(vinGood), .vddGood(vddGood), .disPin(disPin),
    .msTick(msTick), .trig(trig), .strobe(strobe), .irqOut(irqPullDown)
  );

  irqCtlDatapath uDatapath (
    .clk(clk), .rstN(rstN), .stsLevel(stsLevel), .flagSet(flagSet),
    .mskData(mskData), .strobe(strobe), .trig(trig), .rdData(rdData)
  );
endmodule

// File: tb/tb_irqEventCtl.sv
module tb_irqEventCtl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] stsLevel = '0;
  logic [2:0] flagSet = '0;
  logic       rdStb = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       mskWr = 1'b0;
  logic [7:0] mskData = '0;
  logic       detStart = 1'b0;
  logic       vinGood = 1'b1;
  logic       vddGood = 1'b1;
  logic       disPin = 1'b0;
  logic       msTick = 1'b0;
  logic       irqPullDown;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_STS = 4'd2, A_FLG = 4'd3, A_MSK = 4'd4;

  // {mask[15:8], status levels[7:4], flag set[3:1], expected request[0]}
  localparam int NVEC = 9;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 4'b0000, 3'b001, 1'b1},
    {8'h00, 4'b0000, 3'b100, 1'b1},
    {8'h00, 4'b1000, 3'b000, 1'b1},
    {8'h80, 4'b1000, 3'b000, 1'b0},
    {8'h07, 4'b0000, 3'b111, 1'b0},
    {8'h07, 4'b0110, 3'b010, 1'b1},
    {8'hF7, 4'b1111, 3'b111, 1'b0},
    {8'hF0, 4'b0001, 3'b010, 1'b1},
    {8'h08, 4'b0000, 3'b010, 1'b1}
  };

  irqEventCtl dut (
    .clk(clk), .rstN(rstN), .stsLevel(stsLevel), .flagSet(flagSet),
    .rdStb(rdStb), .rdAddr(rdAddr), .rdData(rdData), .mskWr(mskWr),
    .mskData(mskData), .detStart(detStart), .vinGood(vinGood),
    .vddGood(vddGood), .disPin(disPin), .msTick(msTick),
    .irqPullDown(irqPullDown)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] addr, output logic [7:0] data);
    rdStb = 1'b1;
    rdAddr = addr;
    #1 data = rdData;
    @(negedge clk);
    rdStb = 1'b0;
    rdAddr = '0;
  endtask

  task automatic writeMask(input logic [7:0] m);
    mskWr = 1'b1;
    mskData = m;
    @(negedge clk);
    mskWr = 1'b0;
  endtask

  task automatic pulseSet(input logic [2:0] s);
    flagSet = s;
    @(negedge clk);
    flagSet = '0;
  endtask

  task automatic armTicks();
    msTick = 1'b1;
    repeat (2) @(negedge clk);
    msTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irqPullDown, 0);
    readReg(A_STS, d); chk("R1 status", d, 8'h00);
    readReg(A_FLG, d); chk("R1 flags", d, 8'h00);
    readReg(A_MSK, d); chk("R1 mask", d, 8'h00);
    armTicks();

    // Vector table: R5 request, R2 flag latch, R3 status image
    for (int i = 0; i < NVEC; i++) begin
      writeMask(VEC[i][15:8]);
      stsLevel = VEC[i][7:4];
      pulseSet(VEC[i][3:1]);
      chk("R5 vector irq", irqPullDown, VEC[i][0]);
      readReg(A_STS, d); chk("R3 status", d, {VEC[i][7:4], 4'h0});
      readReg(A_FLG, d); chk("R2 flags", d, {5'h0, VEC[i][3:1]});
      chk("R6 released after read", irqPullDown, 0);
      stsLevel = '0;
      @(negedge clk);
      readReg(A_STS, d);
    end
    writeMask(8'h00);

    // R4 mask readback, R12 reserved and unmapped
    writeMask(8'hFF);
    readReg(A_MSK, d); chk("R4 mask reserved bit", d, 8'hF7);
    writeMask(8'h5A);
    readReg(A_MSK, d); chk("R4 mask readback", d, 8'h52);
    writeMask(8'h00);
    readReg(4'd0, d); chk("R12 unmapped", d, 8'h00);
    readReg(4'd9, d); chk("R12 unmapped high", d, 8'h00);

    // R5 held level does not re-raise; R6 status read release
    stsLevel = 4'b0100;
    @(negedge clk);
    chk("R5 level rise", irqPullDown, 1);
    readReg(A_STS, d);
    chk("R6 status read release", irqPullDown, 0);
    repeat (3) @(negedge clk);
    chk("R5 held level quiet", irqPullDown, 0);
    stsLevel = '0;
    @(negedge clk);

    // R2 hold then clear
    pulseSet(3'b001);
    readReg(A_STS, d);
    repeat (4) @(negedge clk);
    readReg(A_FLG, d); chk("R2 held flag", d, 8'h01);
    readReg(A_FLG, d); chk("R2 cleared flag", d, 8'h00);

    // R11 set coinciding with flag read
    pulseSet(3'b100);
    readReg(A_STS, d);
    chk("R11 pre-released", irqPullDown, 0);
    flagSet = 3'b100;
    readReg(A_FLG, d);
    flagSet = '0;
    chk("R11 read value", d, 8'h04);
    chk("R11 irq kept", irqPullDown, 1);
    readReg(A_FLG, d); chk("R11 flag survived", d, 8'h04);
    readReg(A_FLG, d);

    // R7 timeout
    pulseSet(3'b001);
    chk("R7 asserted", irqPullDown, 1);
    msTick = 1'b1;
    repeat (999) @(negedge clk);
    chk("R7 still high at 999", irqPullDown, 1);
    @(negedge clk);
    msTick = 1'b0;
    chk("R7 released at 1000", irqPullDown, 0);
    readReg(A_FLG, d);

    // R8 detection start
    pulseSet(3'b010);
    chk("R8 asserted", irqPullDown, 1);
    detStart = 1'b1;
    @(negedge clk);
    detStart = 1'b0;
    chk("R8 released", irqPullDown, 0);
    readReg(A_FLG, d);

    // R9 disable pin
    pulseSet(3'b010);
    disPin = 1'b1;
    @(negedge clk);
    chk("R9 released", irqPullDown, 0);
    readReg(A_FLG, d);
    pulseSet(3'b001);
    chk("R9 blocked", irqPullDown, 0);
    disPin = 1'b0;
    @(negedge clk);
    chk("R9 stays low", irqPullDown, 0);
    readReg(A_FLG, d);

    // R10 supply loss and settle
    pulseSet(3'b001);
    vinGood = 1'b0;
    @(negedge clk);
    chk("R10 released on power down", irqPullDown, 0);
    readReg(A_FLG, d);
    pulseSet(3'b001);
    chk("R10 blocked unpowered", irqPullDown, 0);
    vinGood = 1'b1;
    pulseSet(3'b010);
    chk("R10 blocked while settling", irqPullDown, 0);
    readReg(A_FLG, d);
    armTicks();
    pulseSet(3'b100);
    chk("R10 active after settle", irqPullDown, 1);
    readReg(A_FLG, d);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule